// File: doc/BRIEF.md
# Multi-Precision SIMD Multiply-Accumulate Unit

This block is a pipelined fixed-point multiply-accumulate datapath on 64-bit operands. A mode input splits the operands into one, two, four or eight equal lanes of 64, 32, 16 or 8 bits. Each lane multiplies its slice of `in_a` by its slice of `in_b`, signed or unsigned, and adds the double-width product to its own slice of a 128-bit accumulator input. All lane widths share one partial-product array. Bits of `in_a` that belong to a different lane than the selected bit of `in_b` are masked out. Carries are killed at lane boundaries in the carry-save tree and in the final adder.

Operations enter and leave over valid/ready streams. An operation transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being consumed in the same cycle. When a result is presented and `out_ready` is low, the whole pipeline holds and `in_ready` falls. While `out_valid` is high, `out_result` keeps its value until the cycle in which `out_ready` is high. Mode and signedness are sampled with each operation and travel down the pipeline with it, so they may change on every transfer.

Top module: `simd_mac`

## Requirements
- R1: `in_mode` selects the lane width w: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes, and 3 gives one 64-bit lane. Lane i of each operand is `in_x[w*i +: w]`, and lane 0 is the least significant.
- R2: The accumulator input and the result are packed the same way: lane i occupies bits `[2w*i +: 2w]`.
- R3: With `in_signed` low, each result lane equals (acc lane + a lane * b lane) mod 2^(2w), with all three taken as unsigned.
- R4: With `in_signed` high, the a and b lanes are two's complement numbers. Each result lane equals (acc lane + a*b) mod 2^(2w).
- R5: No carry or borrow passes from one lane into the next, not even when every lane overflows.
- R6: In signed mode, the most negative lane value multiplied by itself gives 2^(2w-2), plus the accumulator lane.
- R7: With `out_ready` held high, one operation is accepted every cycle. Results leave in order, three cycles after acceptance.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` hold and `in_ready` is low. Otherwise `in_ready` is high.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: Mode and signedness may change on every accepted operation. Each result uses the controls that were sampled with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit takes an operation this cycle |
| in_a | input | 64 | Multiplicand lanes |
| in_b | input | 64 | Multiplier lanes |
| in_acc | input | 128 | Accumulator lanes, each double width |
| in_mode | input | 2 | Lane width select (R1) |
| in_signed | input | 1 | 1: two's complement lanes, 0: unsigned |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | 128 | Lane-packed multiply-accumulate result |

## Verification
Some properties are checked on every cycle by the assertions:
- every masked partial-product row stays inside the result field of its own lane;
- a stalled output keeps its value and holds off new input;
- an operation followed by two unstalled cycles comes out on the third.

The arithmetic itself can only be shown by the bench's scenarios, which compare each result with a reference multiply-add. These scenarios cover:
- all-ones lanes that overflow at every boundary;
- most-negative squares in every mode;
- random signed and unsigned operands;
- mode and sign changing on every transfer;
- random back-pressure on the output.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // True when two operand bit positions fall in the same lane of width 2**lg.
  function automatic logic same_lane(input int unsigned i, input int unsigned j,
                                     input int unsigned lg);
    return (i >> lg) == (j >> lg);
  endfunction

  // True when a product bit is the lowest bit of a double-width lane field,
  // i.e. a carry arriving here would have crossed a lane boundary.
  function automatic logic field_start(input int unsigned k, input int unsigned lg);
    return ((k >> (lg + 1)) << (lg + 1)) == k;
  endfunction

endpackage

// File: rtl/mac_pp_gen.sv
module mac_pp_gen #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned MIN_LOG2 = 3,
  parameter int unsigned MODE_W   = 2,
  localparam int unsigned PROD_W  = 2 * DATA_W,
  localparam int unsigned NROWS   = DATA_W + 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [MODE_W-1:0]              mode,
  input  logic                           is_signed,
  input  logic [DATA_W-1:0]              a,
  input  logic [DATA_W-1:0]              b,
  output logic [NROWS-1:0][PROD_W-1:0]   rows
);
  int unsigned lane_lg;
  assign lane_lg = MIN_LOG2 + int'(mode);

  logic [DATA_W-1:0][PROD_W-1:0] pp;
  logic [PROD_W-1:0] corr_a, corr_b, fix_const;

  // Masked partial products: a[i]*b[j] lands at i+j, which for same-lane
  // bits is already inside that lane's packed result field.
  always_comb begin
    pp = '0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int i = 0; i < DATA_W; i++) begin
        pp[j][i+j] = a[i] & b[j] & mac_pkg::same_lane(i, j, lane_lg);
      end
    end
  end

  // Sign correction: a_s*b_s = a_u*b_u - 2^w*(a_msb*b_u + b_msb*a_u) mod 2^(2w).
  always_comb begin
    int unsigned lw;
    int unsigned base;
    int unsigned msb;
    corr_a    = '0;
    corr_b    = '0;
    fix_const = '0;
    lw = 1 << lane_lg;
    for (int i = 0; i < DATA_W; i++) begin
      base = (i >> lane_lg) << lane_lg;
      msb  = base + lw - 1;
      corr_a[i+base+lw] = b[i] & a[msb];
      corr_b[i+base+lw] = a[i] & b[msb];
    end
    // two +1 terms per lane complete both negations
    for (int k = 0; k < PROD_W; k++) begin
      fix_const[k] = ((k & (2 * lw - 1)) == 1);
    end
  end

  always_comb begin
    for (int j = 0; j < DATA_W; j++) rows[j] = pp[j];
    rows[DATA_W]     = is_signed ? ~corr_a   : '0;
    rows[DATA_W + 1] = is_signed ? ~corr_b   : '0;
    rows[DATA_W + 2] = is_signed ? fix_const : '0;
  end

  logic stray;
  always_comb begin
    stray = 1'b0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int k = 0; k < PROD_W; k++) begin
        if (pp[j][k] && ((k >> (lane_lg + 1)) != (j >> lane_lg))) stray = 1'b1;
      end
    end
  end

  AST_LANE_CONFINED: assert property (@(posedge clk) disable iff (!rst_n) !stray); // R5

endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
  parameter int unsigned W        = 128,
  parameter int unsigned N_IN     = 67,
  parameter int unsigned MIN_LOG2 = 3,
  parameter int unsigned MODE_W   = 2,
  localparam int unsigned LEVELS  = 2 * $clog2(N_IN) + 1
) (
  input  logic [MODE_W-1:0]        mode,
  input  logic [N_IN-1:0][W-1:0]   rows,
  output logic [W-1:0]             sum,
  output logic [W-1:0]             carry
);
  int unsigned lane_lg;
  assign lane_lg = MIN_LOG2 + int'(mode);

  logic [W-1:0] kill;
  always_comb begin
    for (int k = 0; k < W; k++) kill[k] = mac_pkg::field_start(k, lane_lg);
  end

  // Levels of 3:2 compressors; shifted carries are killed at lane field starts.
  always_comb begin
    logic [W-1:0] work [N_IN];
    logic [W-1:0] nxt  [N_IN];
    logic [W-1:0] x, y, z;
    int cnt, k, full, rem;
    for (int n = 0; n < N_IN; n++) work[n] = rows[n];
    cnt = N_IN;
    for (int lvl = 0; lvl < LEVELS; lvl++) begin
      for (int n = 0; n < N_IN; n++) nxt[n] = '0;
      k    = 0;
      full = cnt / 3;
      rem  = cnt - 3 * full;
      for (int t = 0; t < N_IN / 3; t++) begin
        if (t < full) begin
          x = work[3*t];
          y = work[3*t+1];
          z = work[3*t+2];
          nxt[k]   = x ^ y ^ z;
          nxt[k+1] = (((x & y) | (x & z) | (y & z)) << 1) & ~kill;
          k = k + 2;
        end
      end
      for (int r = 0; r < 2; r++) begin
        if (r < rem) nxt[k+r] = work[3*full+r];
      end
      if (cnt > 2) begin
        for (int n = 0; n < N_IN; n++) work[n] = nxt[n];
        cnt = k + rem;
      end
    end
    sum   = work[0];
    carry = (cnt > 1) ? work[1] : '0;
  end

endmodule

// File: rtl/mac_seg_adder.sv
module mac_seg_adder #(
  parameter int unsigned W        = 128,
  parameter int unsigned MIN_LOG2 = 3,
  parameter int unsigned MODE_W   = 2
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      x,
  input  logic [W-1:0]      y,
  output logic [W-1:0]      s
);
  int unsigned lane_lg;
  assign lane_lg = MIN_LOG2 + int'(mode);

  // Carry-propagate adder whose carry is forced to zero at each lane start.
  always_comb begin
    logic c;
    c = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (mac_pkg::field_start(k, lane_lg)) c = 1'b0;
      s[k] = x[k] ^ y[k] ^ c;
      c    = (x[k] & y[k]) | (x[k] & c) | (y[k] & c);
    end
  end

endmodule

// File: rtl/simd_mac.sv
module simd_mac #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned MIN_LANE_W = 8,
  localparam int unsigned PROD_W    = 2 * DATA_W,
  localparam int unsigned MIN_LOG2  = $clog2(MIN_LANE_W),
  localparam int unsigned NUM_MODES = $clog2(DATA_W / MIN_LANE_W) + 1,
  localparam int unsigned MODE_W    = $clog2(NUM_MODES),
  localparam int unsigned NROWS     = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [PROD_W-1:0] in_acc,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              in_signed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_result
);
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // Stage 1: partial products, sign correction, compression to sum/carry
  logic [NROWS-1:0][PROD_W-1:0] pp_rows;
  logic [PROD_W-1:0] t1_sum, t1_carry;

  mac_pp_gen #(.DATA_W(DATA_W), .MIN_LOG2(MIN_LOG2), .MODE_W(MODE_W)) u_pp (
    .clk(clk), .rst_n(rst_n), .mode(in_mode), .is_signed(in_signed),
    .a(in_a), .b(in_b), .rows(pp_rows)
  );

  mac_csa_tree #(.W(PROD_W), .N_IN(NROWS), .MIN_LOG2(MIN_LOG2), .MODE_W(MODE_W)) u_tree (
    .mode(in_mode), .rows(pp_rows), .sum(t1_sum), .carry(t1_carry)
  );

  logic              s1_v;
  logic [MODE_W-1:0] s1_mode;
  logic [PROD_W-1:0] s1_sum, s1_carry, s1_acc;

  // Stage 2: fold accumulator into the carry-save pair
  logic [2:0][PROD_W-1:0] merge_rows;
  logic [PROD_W-1:0] t2_sum, t2_carry;
  assign merge_rows = {s1_acc, s1_carry, s1_sum};

  mac_csa_tree #(.W(PROD_W), .N_IN(3), .MIN_LOG2(MIN_LOG2), .MODE_W(MODE_W)) u_merge (
    .mode(s1_mode), .rows(merge_rows), .sum(t2_sum), .carry(t2_carry)
  );

  logic              s2_v;
  logic [MODE_W-1:0] s2_mode;
  logic [PROD_W-1:0] s2_sum, s2_carry;

  // Stage 3: segmented carry-propagate add
  logic [PROD_W-1:0] t3_res;
  mac_seg_adder #(.W(PROD_W), .MIN_LOG2(MIN_LOG2), .MODE_W(MODE_W)) u_cpa (
    .mode(s2_mode), .x(s2_sum), .y(s2_carry), .s(t3_res)
  );

  logic              s3_v;
  logic [PROD_W-1:0] s3_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else if (advance) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      s1_mode  <= in_mode;
      s1_sum   <= t1_sum;
      s1_carry <= t1_carry;
      s1_acc   <= in_acc;
      s2_mode  <= s1_mode;
      s2_sum   <= t2_sum;
      s2_carry <= t2_carry;
      s3_res   <= t3_res;
    end
  end

  assign out_valid  = s3_v;
  assign out_result = s3_res;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)); // R8

  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready ##1 in_ready ##1 in_ready |=> out_valid); // R7

endmodule

// File: tb/tb_simd_mac.sv
module tb_simd_mac;
  localparam int DW = 64;
  localparam int PW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_a = '0, in_b = '0;
  logic [PW-1:0] in_acc = '0;
  logic [1:0] in_mode = '0;
  logic in_signed = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [PW-1:0] out_result;

  always #5 clk = ~clk;

  simd_mac dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .in_mode(in_mode),
    .in_signed(in_signed), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_on = 0;
  bit finished = 0;

  logic [PW-1:0] exp_q[$];
  string req_q[$];
  int cyc_q[$];
  bit lat_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PW-1:0] ref_mac(logic [DW-1:0] a, logic [DW-1:0] b,
                                            logic [PW-1:0] acc, int mode, bit sgn);
    logic [PW-1:0] r, ea, eb, ec, p;
    int w, n;
    w = 8 << mode;
    n = DW / w;
    r = '0;
    for (int l = 0; l < n; l++) begin
      ea = '0; eb = '0; ec = '0;
      for (int k = 0; k < PW; k++) begin
        if (k < w) begin
          ea[k] = a[l*w+k];
          eb[k] = b[l*w+k];
        end else if (sgn) begin
          ea[k] = a[l*w+w-1];
          eb[k] = b[l*w+w-1];
        end
        if (k < 2*w) ec[k] = acc[2*w*l+k];
      end
      p = ea * eb + ec;
      for (int k = 0; k < 2*w; k++) r[2*w*l+k] = p[k];
    end
    return r;
  endfunction

  task automatic check(string req, bit ok, logic [PW-1:0] act, logic [PW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send_exp(logic [DW-1:0] a, logic [DW-1:0] b, logic [PW-1:0] acc,
                          int mode, bit sgn, logic [PW-1:0] expv, string req);
    @(negedge clk);
    in_valid  = 1'b1;
    in_a      = a;
    in_b      = b;
    in_acc    = acc;
    in_mode   = 2'(mode);
    in_signed = sgn;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(expv);
    req_q.push_back(req);
    cyc_q.push_back(cyc);
    lat_q.push_back(!bp_on);
  endtask

  task automatic send(logic [DW-1:0] a, logic [DW-1:0] b, logic [PW-1:0] acc,
                      int mode, bit sgn, string req);
    send_exp(a, b, acc, mode, sgn, ref_mac(a, b, acc, mode, sgn), req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [DW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [PW-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [DW-1:0] min_neg(int mode);
    logic [DW-1:0] v;
    int w;
    w = 8 << mode;
    v = '0;
    for (int k = 0; k < DW; k++) if ((k % w) == w - 1) v[k] = 1'b1;
    return v;
  endfunction

  // Monitor / scoreboard plus handshake rules
  bit prev_stall = 0;
  logic [PW-1:0] prev_res;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check("R8 in_ready rule", in_ready == (!out_valid || out_ready),
              {127'b0, in_ready}, {127'b0, (!out_valid || out_ready)});
        if (prev_stall)
          check("R8 hold", out_valid && out_result == prev_res, out_result, prev_res);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R7 unexpected result", 1'b0, out_result, '0);
          end else begin
            logic [PW-1:0] e;
            string r;
            int c0;
            bit lt;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            c0 = cyc_q.pop_front();
            lt = lat_q.pop_front();
            check(r, out_result == e, out_result, e);
            if (lt && !bp_on)
              check("R7 latency", (cyc - c0) == 3, PW'(cyc - c0), PW'(3));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_res   = out_result;
      end
    end
  end

  // Output back-pressure driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_on ? 1'($urandom() % 2) : 1'b1;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int start;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 out_valid", out_valid == 1'b0, {127'b0, out_valid}, '0);
    check("R9 in_ready", in_ready == 1'b1, {127'b0, in_ready}, 128'd1);

    // R1 R2 lane layout per mode, small values
    for (int m = 0; m < 4; m++) begin
      logic [DW-1:0] a, b;
      for (int k = 0; k < 8; k++) begin
        a[8*k +: 8] = 8'(k + 1);
        b[8*k +: 8] = 8'(3);
      end
      send(a, b, '0, m, 1'b0, "R1 R2 layout");
    end
    // R6 explicit value in 64-bit lane
    send_exp(min_neg(3), min_neg(3), '0, 3, 1'b1, {2'b01, 126'b0}, "R6 64-bit min squared");
    // R6 explicit value in 8-bit lanes: each lane 0x4000
    send_exp(min_neg(0), min_neg(0), '0, 0, 1'b1, {8{16'h4000}}, "R6 8-bit min squared");
    // R5 all-ones overflow in every mode, both signedness
    for (int m = 0; m < 4; m++) begin
      send('1, '1, '1, m, 1'b0, "R5 unsigned overflow");
      send(min_neg(m), min_neg(m), '1, m, 1'b1, "R5 R6 signed with acc");
      send('1, min_neg(m), '1, m, 1'b1, "R5 signed borrow");
    end
    // R3 / R4 random per mode
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 12; n++) send(rnd64(), rnd64(), rnd128(), m, 1'b0, "R3 unsigned random");
      for (int n = 0; n < 12; n++) send(rnd64(), rnd64(), rnd128(), m, 1'b1, "R4 signed random");
    end
    idle();
    drain();

    // R7 back-to-back throughput: 16 ops in 16 cycles
    start = cyc;
    for (int n = 0; n < 16; n++) send(rnd64(), rnd64(), rnd128(), n % 4, 1'b0, "R7 stream");
    check("R7 throughput", (cyc - start) == 16, PW'(cyc - start), PW'(16));
    idle();
    drain();

    // R10 controls change on every transfer
    for (int n = 0; n < 32; n++)
      send(rnd64(), rnd64(), rnd128(), $urandom() % 4, 1'($urandom() % 2), "R10 mixed controls");
    idle();
    drain();

    // R8 random back-pressure
    bp_on = 1;
    for (int n = 0; n < 48; n++)
      send(rnd64(), rnd64(), rnd128(), $urandom() % 4, 1'($urandom() % 2), "R8 back-pressure");
    idle();
    drain();
    bp_on = 0;
    repeat (4) @(negedge clk);
    check("R7 all results returned", exp_q.size() == 0, PW'(exp_q.size()), '0);
    finish_run();
  end

endmodule